// File: doc/BRIEF.md
# Data Access Alignment Fault Checker

This block sits in the address-generation stage of a processor core and judges every data access before it is issued to memory. Each request carries the linear address, a data-type code, the operand-size attribute, the kind of segment used, the current privilege level, the operating mode and a few qualifier flags. From these the block decides whether the access passes, raises an alignment fault or raises a general-protection fault. The decision appears one clock cycle after the request is accepted, together with the fault vector number, a zero error code and the address of the access.

Two enables gate the alignment fault: a mask bit held in a control register and an alignment bit held in the flags register. The fault applies only to user-level code (privilege 3) running in protected or virtual-8086 mode. Separately, 128-bit data must sit on a 16-byte boundary. If it does not, a general-protection fault is raised whatever the enables say. Unaligned 128-bit move instructions are exempt from that rule but are still subject to the alignment fault.

Requests enter on a valid/ready pair, and verdicts leave on another. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. A verdict that is held back by a low `rsp_ready` stays unchanged and blocks new requests. Segment limits and paging are handled elsewhere.

Top module: `mem_align_guard`

## Requirements
- R1: An alignment fault is possible only when `cr_align_mask`=1, `fl_align`=1, `cpl`=3 and `mode` is protected (1) or virtual-8086 (2). Real mode (0) and mode code 3 are never checked.
- R2: The required boundary depends on the data-type code. Byte (0) needs 1. Word (1), selector (2) and 32-bit far pointer (9) need 2. Dword (3), 32-bit float (4), 48-bit far pointer (5) and table/task-register store (10) need 4. Qword (6), double (7) and 80-bit float (8) need 8. When checking is active, an address that is not a multiple of the boundary gives an alignment fault.
- R3: Environment/save area (11) and bit string (12) need a boundary of 4 when `op32`=1 and 2 when `op32`=0.
- R4: Only data (`seg_kind`=0) and stack (1) accesses can raise the alignment fault. Code (2) and system (3) accesses never do.
- R5: An access with `implicit_sup`=1 never raises the alignment fault, even when `cpl` is 3.
- R6: A 128-bit access (code 13) with `umov`=0 and `addr[3:0]`≠0 gives a general-protection fault, regardless of the enables, the privilege, the mode and the segment kind.
- R7: A 128-bit access with `umov`=1 never gives a general-protection fault. With checking active, it gives an alignment fault exactly when `addr[3:0]` is 2, 4 or 8.
- R8: Verdict codes are pass=0, alignment=1 and general-protection=2. The vector is 17 for alignment, 13 for general-protection and 0 for pass. The error code is always 0. Exactly one verdict is reported per access, and general-protection takes priority.
- R9: Data-type codes 14 and 15 always pass.
- R10: A request accepted at clock edge N gives `rsp_valid`=1 with its verdict after edge N. While `rsp_ready`=0 the response and `rsp_addr` hold and `req_ready`=0. The output is empty after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Linear address |
| req_dtype | input | 4 | Data-type code (R2, R3, R6, R9) |
| req_op32 | input | 1 | Operand size is 32 bits |
| req_seg_kind | input | 2 | 0 data, 1 stack, 2 code, 3 system |
| req_cpl | input | 2 | Current privilege level |
| req_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 other |
| req_implicit_sup | input | 1 | Access performed implicitly at privilege 0 |
| req_umov | input | 1 | Unaligned 128-bit move instruction |
| cr_align_mask | input | 1 | Control-register alignment mask bit |
| fl_align | input | 1 | Flags-register alignment bit |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_verdict | output | 2 | 0 pass, 1 alignment fault, 2 general-protection fault |
| rsp_vector | output | 8 | Fault vector (17, 13 or 0) |
| rsp_err_code | output | ERR_W | Error code pushed for the fault (zero) |
| rsp_addr | output | ADDR_W | Address of the judged access |

## Verification
A wrong boundary decode or a wrong enable term shows up as a wrong verdict code in the very next cycle after acceptance. Because the vector and error code are derived from the same registered verdict, an error there shows at the same time. A broken output register shows as a verdict that changes or disappears while `rsp_ready` is low. It can also show as `req_ready` staying high while a verdict is held. Either symptom is visible within one cycle of the stall.

// File: rtl/align_chk_pkg.sv
package align_chk_pkg;
  localparam logic [3:0] DT_BYTE  = 4'd0;
  localparam logic [3:0] DT_WORD  = 4'd1;
  localparam logic [3:0] DT_SEL   = 4'd2;
  localparam logic [3:0] DT_DWORD = 4'd3;
  localparam logic [3:0] DT_F32   = 4'd4;
  localparam logic [3:0] DT_FAR48 = 4'd5;
  localparam logic [3:0] DT_QWORD = 4'd6;
  localparam logic [3:0] DT_F64   = 4'd7;
  localparam logic [3:0] DT_F80   = 4'd8;
  localparam logic [3:0] DT_FAR32 = 4'd9;
  localparam logic [3:0] DT_DTR   = 4'd10;
  localparam logic [3:0] DT_ENV   = 4'd11;
  localparam logic [3:0] DT_BITS  = 4'd12;
  localparam logic [3:0] DT_V128  = 4'd13;

  localparam logic [1:0] SEG_DATA  = 2'd0;
  localparam logic [1:0] SEG_STACK = 2'd1;

  localparam logic [1:0] MODE_PROT = 2'd1;
  localparam logic [1:0] MODE_V86  = 2'd2;

  typedef enum logic [1:0] {
    VD_PASS  = 2'd0,
    VD_ALIGN = 2'd1,
    VD_GP    = 2'd2
  } verdict_e;

  localparam logic [7:0] VEC_ALIGN = 8'd17;
  localparam logic [7:0] VEC_GP    = 8'd13;
  localparam logic [7:0] VEC_NONE  = 8'd0;
endpackage

// File: rtl/align_size_decode.sv
module align_size_decode
  import align_chk_pkg::*;
(
  input  logic [3:0] dtype,
  input  logic       op32,
  output logic [3:0] low_mask,
  output logic       is_v128
);
  always_comb begin
    is_v128 = (dtype == DT_V128);
    unique case (dtype)
      DT_WORD, DT_SEL, DT_FAR32:          low_mask = 4'b0001;
      DT_DWORD, DT_F32, DT_FAR48, DT_DTR: low_mask = 4'b0011;
      DT_QWORD, DT_F64, DT_F80:           low_mask = 4'b0111;
      DT_ENV, DT_BITS:                    low_mask = op32 ? 4'b0011 : 4'b0001;
      DT_V128:                            low_mask = 4'b1111;
      default:                            low_mask = 4'b0000;
    endcase
  end
endmodule

// File: rtl/align_fault_eval.sv
module align_fault_eval
  import align_chk_pkg::*;
(
  input  logic [3:0] addr_lo,
  input  logic [3:0] low_mask,
  input  logic       is_v128,
  input  logic [1:0] seg_kind,
  input  logic [1:0] cpl,
  input  logic [1:0] mode,
  input  logic       implicit_sup,
  input  logic       umov,
  input  logic       cr_align_mask,
  input  logic       fl_align,
  output logic [1:0] verdict
);
  logic checking_on;
  logic seg_checked;
  logic off_boundary;
  logic umov_hit;

  always_comb begin
    checking_on  = cr_align_mask && fl_align && (cpl == 2'd3) &&
                   ((mode == MODE_PROT) || (mode == MODE_V86));
    seg_checked  = (seg_kind == SEG_DATA) || (seg_kind == SEG_STACK);
    off_boundary = |(addr_lo & low_mask);
    umov_hit     = (addr_lo == 4'd2) || (addr_lo == 4'd4) || (addr_lo == 4'd8);

    verdict = VD_PASS;
    if (is_v128 && !umov && off_boundary) begin
      verdict = VD_GP;
    end else if (checking_on && seg_checked && !implicit_sup) begin
      if (is_v128) begin
        if (umov_hit) verdict = VD_ALIGN;
      end else if (off_boundary) begin
        verdict = VD_ALIGN;
      end
    end
  end
endmodule

// File: rtl/align_out_stage.sv
module align_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/mem_align_guard.sv
module mem_align_guard
  import align_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_dtype,
  input  logic              req_op32,
  input  logic [1:0]        req_seg_kind,
  input  logic [1:0]        req_cpl,
  input  logic [1:0]        req_mode,
  input  logic              req_implicit_sup,
  input  logic              req_umov,
  input  logic              cr_align_mask,
  input  logic              fl_align,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_verdict,
  output logic [7:0]        rsp_vector,
  output logic [ERR_W-1:0]  rsp_err_code,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int PAY_W = ADDR_W + 2;

  logic [3:0]       low_mask;
  logic             is_v128;
  logic [1:0]       verdict_c;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  align_size_decode u_dec (
    .dtype    (req_dtype),
    .op32     (req_op32),
    .low_mask (low_mask),
    .is_v128  (is_v128)
  );

  align_fault_eval u_eval (
    .addr_lo       (req_addr[3:0]),
    .low_mask      (low_mask),
    .is_v128       (is_v128),
    .seg_kind      (req_seg_kind),
    .cpl           (req_cpl),
    .mode          (req_mode),
    .implicit_sup  (req_implicit_sup),
    .umov          (req_umov),
    .cr_align_mask (cr_align_mask),
    .fl_align      (fl_align),
    .verdict       (verdict_c)
  );

  assign pay_in = {req_addr, verdict_c};

  align_out_stage #(.W(PAY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pay_in),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (pay_out)
  );

  assign rsp_verdict  = pay_out[1:0];
  assign rsp_addr     = pay_out[PAY_W-1:2];
  assign rsp_err_code = '0;

  always_comb begin
    unique case (rsp_verdict)
      VD_ALIGN: rsp_vector = VEC_ALIGN;
      VD_GP:    rsp_vector = VEC_GP;
      default:  rsp_vector = VEC_NONE;
    endcase
  end
endmodule

// File: rtl/align_chk_props.sv
module align_chk_props #(
  parameter int ADDR_W = 32,
  parameter int ERR_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_dtype,
  input logic              req_seg_kind_hi,
  input logic              req_implicit_sup,
  input logic              req_umov,
  input logic              cr_align_mask,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_verdict,
  input logic [7:0]        rsp_vector,
  input logic [ERR_W-1:0]  rsp_err_code,
  input logic [ADDR_W-1:0] rsp_addr
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_NO_AC_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cr_align_mask |=> rsp_valid && rsp_verdict != 2'd1); // R1

  AST_NO_AC_CODE_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_seg_kind_hi |=> rsp_verdict != 2'd1); // R4

  AST_NO_AC_IMPLICIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_implicit_sup |=> rsp_verdict != 2'd1); // R5

  AST_GP_WIDE_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_dtype == 4'd13 && !req_umov && req_addr[3:0] != 4'd0
    |=> rsp_valid && rsp_verdict == 2'd2); // R6

  AST_NO_GP_UMOV: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_umov |=> rsp_verdict != 2'd2); // R7

  AST_VECTOR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_err_code == '0 &&
      ((rsp_verdict == 2'd1) == (rsp_vector == 8'd17)) &&
      ((rsp_verdict == 2'd2) == (rsp_vector == 8'd13)) &&
      rsp_verdict != 2'd3); // R8

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_verdict) &&
      $stable(rsp_addr)); // R10

  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R10
endmodule

bind mem_align_guard align_chk_props #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_props (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .req_addr         (req_addr),
  .req_dtype        (req_dtype),
  .req_seg_kind_hi  (req_seg_kind[1]),
  .req_implicit_sup (req_implicit_sup),
  .req_umov         (req_umov),
  .cr_align_mask    (cr_align_mask),
  .rsp_valid        (rsp_valid),
  .rsp_ready        (rsp_ready),
  .rsp_verdict      (rsp_verdict),
  .rsp_vector       (rsp_vector),
  .rsp_err_code     (rsp_err_code),
  .rsp_addr         (rsp_addr)
);

// File: tb/mem_align_guard_tb_top.sv
module mem_align_guard_tb_top;
  localparam int ADDR_W = 32;
  localparam int ERR_W  = 16;
  localparam int NV     = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0]        req_dtype = '0;
  logic              req_op32 = 1'b0;
  logic [1:0]        req_seg_kind = '0;
  logic [1:0]        req_cpl = '0;
  logic [1:0]        req_mode = '0;
  logic              req_implicit_sup = 1'b0;
  logic              req_umov = 1'b0;
  logic              cr_align_mask = 1'b0;
  logic              fl_align = 1'b0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [1:0]        rsp_verdict;
  logic [7:0]        rsp_vector;
  logic [ERR_W-1:0]  rsp_err_code;
  logic [ADDR_W-1:0] rsp_addr;

  int checks = 0;
  int errors = 0;

  mem_align_guard #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) dut_i (.*);

  // Fields: dtype, op32, seg, cpl, mode, implicit, umov, mask, flag, addr[7:0], verdict, req
  localparam logic [28:0] VEC [NV] = '{
    {4'd1, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 2'd1, 4'd2}, // R2 word odd
    {4'd1, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h02, 2'd0, 4'd2}, // R2 word even
    {4'd2, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h03, 2'd1, 4'd2}, // R2 selector
    {4'd3, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h02, 2'd1, 4'd2}, // R2 dword
    {4'd4, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0C, 2'd0, 4'd2}, // R2 float32
    {4'd5, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h04, 2'd0, 4'd2}, // R2 far48 ok
    {4'd5, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h06, 2'd1, 4'd2}, // R2 far48 bad
    {4'd8, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h04, 2'd1, 4'd2}, // R2 f80
    {4'd6, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h08, 2'd0, 4'd2}, // R2 qword
    {4'd7, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0C, 2'd1, 4'd2}, // R2 double
    {4'd9, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h02, 2'd0, 4'd2}, // R2 far32 ok
    {4'd9, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h03, 2'd1, 4'd2}, // R2 far32 bad
    {4'd10,1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h06, 2'd1, 4'd2}, // R2 table store
    {4'd0, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h07, 2'd0, 4'd2}, // R2 byte
    {4'd11,1'b1, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h02, 2'd1, 4'd3}, // R3 env 32
    {4'd11,1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h02, 2'd0, 4'd3}, // R3 env 16
    {4'd12,1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 2'd1, 4'd3}, // R3 bits 16
    {4'd1, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 2'd0, 4'd1}, // R1 mask off
    {4'd1, 1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 2'd0, 4'd1}, // R1 flag off
    {4'd1, 1'b0, 2'd0, 2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 2'd0, 4'd1}, // R1 cpl 2
    {4'd1, 1'b0, 2'd0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 2'd0, 4'd1}, // R1 real
    {4'd1, 1'b0, 2'd0, 2'd3, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 2'd1, 4'd1}, // R1 v86
    {4'd1, 1'b0, 2'd0, 2'd3, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 2'd0, 4'd1}, // R1 mode 3
    {4'd1, 1'b0, 2'd1, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 2'd1, 4'd4}, // R4 stack
    {4'd1, 1'b0, 2'd2, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 2'd0, 4'd4}, // R4 code
    {4'd3, 1'b0, 2'd3, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h02, 2'd0, 4'd4}, // R4 system
    {4'd3, 1'b0, 2'd0, 2'd3, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h02, 2'd0, 4'd5}, // R5 implicit
    {4'd13,1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 2'd2, 4'd6}, // R6 no enables
    {4'd13,1'b0, 2'd2, 2'd3, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h01, 2'd2, 4'd6}, // R6 GP wins
    {4'd13,1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h10, 2'd0, 4'd6}, // R6 aligned
    {4'd13,1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h04, 2'd1, 4'd7}, // R7 off 4
    {4'd13,1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h08, 2'd1, 4'd7}, // R7 off 8
    {4'd13,1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0C, 2'd0, 4'd7}, // R7 off 12
    {4'd13,1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h02, 2'd0, 4'd7}, // R7 masked
    {4'd14,1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h07, 2'd0, 4'd9}, // R9 code 14
    {4'd15,1'b0, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h05, 2'd0, 4'd9}  // R9 code 15
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [28:0] v, input logic [31:0] hi);
    {req_dtype, req_op32, req_seg_kind, req_cpl, req_mode, req_implicit_sup,
     req_umov, cr_align_mask, fl_align} = v[28:14];
    req_addr  = {hi[31:8], v[13:6]};
    req_valid = 1'b1;
  endtask

  function automatic logic [7:0] vec_of(input logic [1:0] vd);
    return (vd == 2'd1) ? 8'd17 : (vd == 2'd2) ? 8'd13 : 8'd0;
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R10 reset empty", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 idle after reset",
          {rsp_valid, req_ready}, 1);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] hi;
      hi = 32'hA5C3_0000 + (i << 8);
      drive(VEC[i], hi);
      @(negedge clk);
      check(rsp_valid && rsp_verdict == VEC[i][5:4],
            $sformatf("R%0d vector %0d verdict", VEC[i][3:0], i),
            {rsp_valid, rsp_verdict}, {1'b1, VEC[i][5:4]});
      check(rsp_vector == vec_of(VEC[i][5:4]) && rsp_err_code == '0,
            $sformatf("R8 vector %0d code", i), {rsp_vector, rsp_err_code},
            {vec_of(VEC[i][5:4]), 16'h0});
      check(rsp_addr == {hi[31:8], VEC[i][13:6]}, "R10 address carried",
            rsp_addr, {hi[31:8], VEC[i][13:6]});
    end
    req_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 drains", rsp_valid, 0);

    // R10 back-pressure: hold the fault verdict while the consumer stalls
    rsp_ready = 1'b0;
    drive(VEC[0], 32'h1234_5600);
    @(negedge clk);
    check(rsp_valid && rsp_verdict == 2'd1, "R10 stall first", rsp_verdict, 1);
    check(req_ready == 1'b0, "R10 ready low on stall", req_ready, 0);
    drive(VEC[1], 32'h7777_0000);
    @(negedge clk);
    check(rsp_valid && rsp_verdict == 2'd1 && rsp_addr == 32'h1234_5601,
          "R10 held", rsp_addr, 32'h1234_5601);
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid && rsp_verdict == 2'd0 && rsp_addr == 32'h7777_0002,
          "R10 next after release", rsp_addr, 32'h7777_0002);
    req_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 empty at end", rsp_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule